// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Divider

This unit computes the quotient of two IEEE-754 single-precision operands for a processor pipeline. A one-cycle `start` pulse captures operand A (`opnd_a`) and operand B (`opnd_b`). The value produced is B divided by A. Both operands are classified as zero, normal, denormal, infinity, quiet NaN or signaling NaN. The special cases are resolved in a fixed priority order, each with a fixed result. The mantissa quotient of two normal operands is formed by a restoring shift-subtract loop that produces one quotient bit per clock. The loop yields 26 quotient bits, and the remainder supplies the sticky information for round-to-nearest-even.

The unit takes a fixed number of cycles for every operation, and the count does not depend on the data. The count is 28 cycles by default and 30 cycles when the `AREA_OPT` parameter is set. When an operation raises an exception, the unit does three things: it pulses `exc`, it loads the exception cause code, and it ORs that operation's flags into the sticky flag register. If `trap_en` was high when the operation started, the result register keeps its previous value; otherwise the canned result is written. Denormal arithmetic is not supported, so a denormal operand is rejected.

Top module: `fpdiv_unit`

## Requirements
- R1: When both operands are normal and none of the conditions in R2 to R8 applies, `result` is B/A rounded to nearest-even. Its sign is the XOR of the operand signs. Its biased exponent is expB - expA + 127, less one when the mantissa quotient is below 1, and plus one when rounding carries out of the mantissa.
- R2: A denormal operand (exponent 0, fraction non-zero) takes precedence over every other case. The result is 0xFFC00000, flag bit 0 (denormal operand) is set, and the cause code becomes 5'b00110.
- R3: If R2 does not apply, the result is 0xFFC00000, flag bit 4 (invalid) is set and the cause becomes 5'b00110 in any of these cases: a signaling NaN (exponent 255, fraction MSB 0, fraction non-zero) in either operand, both operands zero, or both operands infinite.
- R4: If R2 and R3 do not apply, a quiet NaN (exponent 255, fraction MSB 1) in either operand gives 0xFFC00000. It sets no flag and raises no exception.
- R5: If none of the above applies, and A is zero while B is not infinite, the result is an infinity carrying the quotient sign. Flag bit 3 (divide by zero) is set and the cause becomes 5'b00110.
- R6: For normal operands, a normalized biased exponent below 1 before rounding gives a zero carrying the quotient sign. Flag bit 1 (underflow) is set and the cause becomes 5'b00110.
- R7: For normal operands, a biased exponent of 255 or more after rounding gives an infinity carrying the quotient sign. Flag bit 2 (overflow) is set and the cause becomes 5'b00110.
- R8: Three cases raise no exception. With B infinite and A finite, the result is an infinity carrying the quotient sign. With A infinite and B finite, or with B zero and A non-zero finite, the result is a zero carrying the quotient sign.
- R9: `done` and the new result appear exactly 28 cycles after the clock edge that accepts `start`, or 30 cycles when `AREA_OPT` = 1. `done` lasts one cycle, and `busy` is high from the accepting edge until `done`.
- R10: A `start` that arrives while `busy` is high is ignored. It does not change the result, and it produces no extra `done`.
- R11: On an exception, `exc` pulses together with `done` and `cause` is loaded with 5'b00110. If `trap_en` was high at start, `result` keeps its previous value; otherwise `result` receives the canned value. `cause` holds its value when no exception occurs.
- R12: `op_flags` shows the flags of the last completed operation. `sticky_flags` accumulates them by OR and clears only on reset. After reset, `busy`, `done`, `exc`, `result`, `cause` and both flag outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a division |
| trap_en | input | 1 | Exceptions trap: keep result unchanged on exception |
| opnd_a | input | 32 | Operand A (divisor) |
| opnd_b | input | 32 | Operand B (dividend) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Quotient register |
| exc | output | 1 | Exception raised by the completing operation |
| cause | output | 5 | Exception cause code |
| op_flags | output | 5 | Flags of the last operation: [4] invalid, [3] div-by-zero, [2] overflow, [1] underflow, [0] denormal |
| sticky_flags | output | 5 | Accumulated flags, same bit order |

## Verification
Every ordered pair drawn from a set of twelve representative values is driven through two instances, one at each latency. The set covers signed zeros, infinities, both kinds of NaN, denormals of both signs, and normals near the range limits. This sweep separates the priority ranks from one another: one pair can satisfy several rules at once, and only the highest-ranked rule should decide the outcome. A run of random normal operand pairs over the full exponent range then exercises the quotient, the exponent adjustment and the rounding. This run also lands on both sides of the overflow and underflow limits. Directed pairs with exact and inexact quotients, including cases where the rounding carries, separate a truncating design from one that rounds to nearest-even. Alternating `trap_en` across the sweep and firing a `start` in the middle of an operation separate the result-hold rule from the ignore-while-busy rule.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int QBITS   = MANT_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int CAUSE_W = 5;
    localparam int FLAG_W  = 5;

    localparam logic [WORD_W-1:0]  CANNED_NAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [CAUSE_W-1:0] CAUSE_FP   = 5'b00110;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_NORM,
        CL_DNZ,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } opclass_e;

    typedef struct packed {
        logic inval;
        logic divz;
        logic ovf;
        logic unf;
        logic dnz;
    } fflags_t;
endpackage

// File: rtl/fpdiv_classify.sv
module fpdiv_classify
    import fpdiv_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    output opclass_e          cls
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    always_comb begin
        ex = op[WORD_W-2 -: EXP_W];
        fr = op[FRAC_W-1:0];
        if (ex == '0) begin
            cls = (fr == '0) ? CL_ZERO : CL_DNZ;
        end else if (ex == {EXP_W{1'b1}}) begin
            if (fr == '0)            cls = CL_INF;
            else if (fr[FRAC_W-1])   cls = CL_QNAN;
            else                     cls = CL_SNAN;
        end else begin
            cls = CL_NORM;
        end
    end
endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter
    import fpdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MANT_W-1:0] dividend,
    input  logic [MANT_W-1:0] divisor,
    output logic [QBITS-1:0]  quo,
    output logic              rem_nz,
    output logic              running
);
    localparam int CW = $clog2(QBITS + 1);

    typedef struct packed {
        logic [MANT_W:0]  rem;
        logic [QBITS-1:0] quo;
        logic [CW-1:0]    cnt;
        logic             run;
    } iter_t;

    iter_t           it_d, it_q;
    logic [MANT_W:0] diff;
    logic            qbit;

    always_comb begin
        it_d = it_q;
        qbit = 1'b0;
        diff = it_q.rem;
        if (load) begin
            it_d.rem = {1'b0, dividend};
            it_d.quo = '0;
            it_d.cnt = '0;
            it_d.run = 1'b1;
        end else if (it_q.run) begin
            qbit     = (it_q.rem >= {1'b0, divisor});
            diff     = qbit ? (it_q.rem - {1'b0, divisor}) : it_q.rem;
            it_d.rem = {diff[MANT_W-1:0], 1'b0};
            it_d.quo = {it_q.quo[QBITS-2:0], qbit};
            it_d.cnt = it_q.cnt + 1'b1;
            if (it_q.cnt == CW'(QBITS - 1)) begin
                it_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) it_q <= '0;
        else        it_q <= it_d;
    end

    assign quo     = it_q.quo;
    assign rem_nz  = |it_q.rem;
    assign running = it_q.run;

    // R1: partial remainder always stays below twice the divisor
    a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        it_q.run |-> (it_q.rem < {divisor, 1'b0}));

    // R9: the loop stops after exactly QBITS steps
    a_r9_iter_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(it_q.run) |-> (it_q.cnt == CW'(QBITS)));
endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round
    import fpdiv_pkg::*;
(
    input  logic [QBITS-1:0]  quo,
    input  logic              rem_nz,
    input  logic [EXP_W-1:0]  exp_a,
    input  logic [EXP_W-1:0]  exp_b,
    input  logic              sign,
    output logic [WORD_W-1:0] rounded,
    output logic              underflow,
    output logic              overflow
);
    localparam int EW = EXP_W + 3;

    logic                 norm;
    logic [MANT_W-1:0]    mant;
    logic                 guard;
    logic                 sticky;
    logic                 up;
    logic [MANT_W:0]      mant_r;
    logic [FRAC_W-1:0]    frac;
    logic signed [EW-1:0] e_pre;
    logic signed [EW-1:0] e_fin;

    always_comb begin
        norm   = quo[QBITS-1];
        mant   = norm ? quo[QBITS-1:2] : quo[QBITS-2:1];
        guard  = norm ? quo[1] : quo[0];
        sticky = rem_nz | (norm & quo[0]);
        up     = guard & (sticky | mant[0]);
        mant_r = {1'b0, mant} + {{MANT_W{1'b0}}, up};
        e_pre  = EW'(exp_b) - EW'(exp_a) + EW'(BIAS) - {{(EW-1){1'b0}}, ~norm};
        e_fin  = e_pre + {{(EW-1){1'b0}}, mant_r[MANT_W]};
        frac   = mant_r[MANT_W] ? '0 : mant_r[FRAC_W-1:0];
        underflow = (e_pre < 1);
        overflow  = !underflow && (e_fin >= EXP_MAX);
        rounded   = {sign, e_fin[EXP_W-1:0], frac};
    end
endmodule

// File: rtl/fpdiv_unit.sv
module fpdiv_unit
    import fpdiv_pkg::*;
#(
    parameter bit AREA_OPT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               trap_en,
    input  logic [WORD_W-1:0]  opnd_a,
    input  logic [WORD_W-1:0]  opnd_b,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  result,
    output logic               exc,
    output logic [CAUSE_W-1:0] cause,
    output logic [FLAG_W-1:0]  op_flags,
    output logic [FLAG_W-1:0]  sticky_flags
);
    localparam int LAT   = AREA_OPT ? 30 : 28;
    localparam int CNT_W = $clog2(LAT);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic               exc;
        logic               trap;
        logic [CNT_W-1:0]   cnt;
        logic [WORD_W-1:0]  a;
        logic [WORD_W-1:0]  b;
        logic [WORD_W-1:0]  result;
        logic [CAUSE_W-1:0] cause;
        fflags_t            op_flags;
        fflags_t            sticky;
    } unit_t;

    unit_t             st_d, st_q;
    opclass_e          cls_a, cls_b;
    logic              accept;
    logic [QBITS-1:0]  it_quo;
    logic              it_rem_nz;
    logic              it_running;
    logic [WORD_W-1:0] rnd_word;
    logic              rnd_unf, rnd_ovf;
    logic              q_sign;
    logic [WORD_W-1:0] fin_res;
    fflags_t           fin_flags;
    logic              fin_exc;

    fpdiv_classify u_cls_a (.op(st_q.a), .cls(cls_a));
    fpdiv_classify u_cls_b (.op(st_q.b), .cls(cls_b));

    assign accept = start && !st_q.busy;

    fpdiv_iter u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .dividend ({1'b1, opnd_b[FRAC_W-1:0]}),
        .divisor  ({1'b1, st_q.a[FRAC_W-1:0]}),
        .quo      (it_quo),
        .rem_nz   (it_rem_nz),
        .running  (it_running)
    );

    assign q_sign = st_q.a[WORD_W-1] ^ st_q.b[WORD_W-1];

    fpdiv_round u_round (
        .quo       (it_quo),
        .rem_nz    (it_rem_nz),
        .exp_a     (st_q.a[WORD_W-2 -: EXP_W]),
        .exp_b     (st_q.b[WORD_W-2 -: EXP_W]),
        .sign      (q_sign),
        .rounded   (rnd_word),
        .underflow (rnd_unf),
        .overflow  (rnd_ovf)
    );

    // Special-case resolution in fixed priority order
    always_comb begin
        fin_res   = CANNED_NAN;
        fin_flags = '0;
        if (cls_a == CL_DNZ || cls_b == CL_DNZ) begin
            fin_flags.dnz = 1'b1;
        end else if (cls_a == CL_SNAN || cls_b == CL_SNAN ||
                     (cls_a == CL_ZERO && cls_b == CL_ZERO) ||
                     (cls_a == CL_INF && cls_b == CL_INF)) begin
            fin_flags.inval = 1'b1;
        end else if (cls_a == CL_QNAN || cls_b == CL_QNAN) begin
            fin_res = CANNED_NAN;
        end else if (cls_a == CL_ZERO && cls_b != CL_INF) begin
            fin_res        = {q_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            fin_flags.divz = 1'b1;
        end else if (cls_b == CL_INF) begin
            fin_res = {q_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cls_a == CL_INF || cls_b == CL_ZERO) begin
            fin_res = {q_sign, {(WORD_W-1){1'b0}}};
        end else if (rnd_unf) begin
            fin_res       = {q_sign, {(WORD_W-1){1'b0}}};
            fin_flags.unf = 1'b1;
        end else if (rnd_ovf) begin
            fin_res       = {q_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            fin_flags.ovf = 1'b1;
        end else begin
            fin_res = rnd_word;
        end
        fin_exc = |fin_flags;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.exc  = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(LAT - 1);
            st_d.a    = opnd_a;
            st_d.b    = opnd_b;
            st_d.trap = trap_en;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
                st_d.exc      = fin_exc;
                st_d.op_flags = fin_flags;
                st_d.sticky   = st_q.sticky | fin_flags;
                if (fin_exc) begin
                    st_d.cause = CAUSE_FP;
                end
                if (!(fin_exc && st_q.trap)) begin
                    st_d.result = fin_res;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy         = st_q.busy;
    assign done         = st_q.done;
    assign result       = st_q.result;
    assign exc          = st_q.exc;
    assign cause        = st_q.cause;
    assign op_flags     = st_q.op_flags;
    assign sticky_flags = st_q.sticky;

    // R9: completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R9: completion only follows a busy period
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy));

    // R9: the mantissa loop has finished before the result is taken
    a_r9_loop_finished: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == '0) |-> !it_running);

    // R11: an exception always carries the floating-point cause code
    a_r11_cause_code: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.exc |-> (st_q.cause == CAUSE_FP));

    // R11: a trapped exception leaves the result register untouched
    a_r11_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.exc && st_q.trap) |-> $stable(st_q.result));

    // R4: an operation without flags raises no exception
    a_r4_no_flag_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.op_flags == '0) |-> !st_q.exc);

    // R12: sticky flags never drop a bit outside reset
    a_r12_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.sticky) & ~st_q.sticky) == '0));
endmodule

// File: tb/fpdiv_unit_tb.sv
`timescale 1ns/1ps
module fpdiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        trap_en = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;

    logic        busy_f, done_f, exc_f, busy_s, done_s, exc_s;
    logic [31:0] result_f, result_s;
    logic [4:0]  cause_f, cause_s, opfl_f, opfl_s, stk_f, stk_s;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] model_res = '0;
    logic [4:0]  model_stk = '0;
    logic [4:0]  model_cause = '0;

    always #10 clk = ~clk;

    fpdiv_unit #(.AREA_OPT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .trap_en(trap_en),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy_f), .done(done_f),
        .result(result_f), .exc(exc_f), .cause(cause_f),
        .op_flags(opfl_f), .sticky_flags(stk_f));

    fpdiv_unit #(.AREA_OPT(1'b1)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .start(start), .trap_en(trap_en),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy_s), .done(done_s),
        .result(result_s), .exc(exc_s), .cause(cause_s),
        .op_flags(opfl_s), .sticky_flags(stk_s));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Reference quotient B/A with flags: [4] invalid [3] divz [2] ovf [1] unf [0] dnz
    function automatic void ref_div(input logic [31:0] a, input logic [31:0] b,
                                    output logic [31:0] res, output logic [4:0] fl,
                                    output string tag);
        logic [7:0]  ea = a[30:23];
        logic [7:0]  eb = b[30:23];
        bit za = (ea == 0) && (a[22:0] == 0);
        bit zb = (eb == 0) && (b[22:0] == 0);
        bit da = (ea == 0) && (a[22:0] != 0);
        bit db = (eb == 0) && (b[22:0] != 0);
        bit ia = (ea == 255) && (a[22:0] == 0);
        bit ib = (eb == 255) && (b[22:0] == 0);
        bit qa = (ea == 255) && a[22];
        bit qb = (eb == 255) && b[22];
        bit sa = (ea == 255) && !a[22] && (a[22:0] != 0);
        bit sb = (eb == 255) && !b[22] && (b[22:0] != 0);
        logic sg = a[31] ^ b[31];
        logic [31:0] inf_w  = {sg, 8'hFF, 23'd0};
        logic [31:0] zero_w = {sg, 31'd0};
        res = 32'hFFC00000;
        fl  = 5'b00000;
        if (da || db) begin
            fl = 5'b00001; tag = "R2";
        end else if (sa || sb || (za && zb) || (ia && ib)) begin
            fl = 5'b10000; tag = "R3";
        end else if (qa || qb) begin
            tag = "R4";
        end else if (za && !ib) begin
            res = inf_w; fl = 5'b01000; tag = "R5";
        end else if (ib) begin
            res = inf_w; tag = "R8";
        end else if (ia || zb) begin
            res = zero_w; tag = "R8";
        end else begin
            longint ma = {41'd0, 1'b1, a[22:0]};
            longint mb = {41'd0, 1'b1, b[22:0]};
            longint qq = (mb << 25) / ma;
            longint rr = (mb << 25) % ma;
            longint mant;
            int     e;
            bit     g, s;
            if (qq >= (64'sd1 << 25)) begin
                mant = qq >> 2; g = qq[1]; s = qq[0] || (rr != 0);
                e = int'(eb) - int'(ea) + 127;
            end else begin
                mant = qq >> 1; g = qq[0]; s = (rr != 0);
                e = int'(eb) - int'(ea) + 126;
            end
            if (e < 1) begin
                res = zero_w; fl = 5'b00010; tag = "R6";
            end else begin
                if (g && (s || mant[0])) mant = mant + 1;
                if (mant == (64'sd1 << 24)) begin
                    mant = mant >> 1; e = e + 1;
                end
                if (e >= 255) begin
                    res = inf_w; fl = 5'b00100; tag = "R7";
                end else begin
                    res = {sg, e[7:0], mant[22:0]}; tag = "R1";
                end
            end
        end
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic trap, input bit poke);
        logic [31:0] e_res;
        logic [4:0]  e_fl;
        string       tag;
        int          fast_at = -1;
        int          slow_at = -1;
        int          fast_n = 0;
        int          slow_n = 0;
        logic [31:0] g_res = '0, g_res_s = '0;
        logic [4:0]  g_fl = '0, g_stk = '0, g_cause = '0, g_fl_s = '0;
        logic        g_exc = 1'b0;
        ref_div(a, b, e_res, e_fl, tag);
        @(negedge clk);
        opnd_a = a; opnd_b = b; trap_en = trap; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy after accept", {31'd0, busy_f}, 32'd1);
        for (int k = 0; k < 34; k++) begin
            if (poke && k == 5) begin
                opnd_a = 32'h3F800000; opnd_b = 32'h40400000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done_f) begin
                fast_n++;
                if (fast_at < 0) begin
                    fast_at = k; g_res = result_f; g_fl = opfl_f;
                    g_stk = stk_f; g_cause = cause_f; g_exc = exc_f;
                end
            end
            if (done_s) begin
                slow_n++;
                if (slow_at < 0) begin
                    slow_at = k; g_res_s = result_s; g_fl_s = opfl_s;
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (e_fl != 0) model_cause = 5'b00110;
        if (!(e_fl != 0 && trap)) model_res = e_res;
        model_stk = model_stk | e_fl;
        chk("R9", "latency default", fast_at, 28);
        chk("R9", "latency area", slow_at, 30);
        chk(poke ? "R10" : "R9", "done pulses", fast_n, 1);
        chk(poke ? "R10" : "R9", "done pulses area", slow_n, 1);
        chk((e_fl != 0 && trap) ? "R11" : tag, "result", g_res, model_res);
        chk(tag, "result area", g_res_s, model_res);
        chk(tag, "op_flags", {27'd0, g_fl}, {27'd0, e_fl});
        chk(tag, "op_flags area", {27'd0, g_fl_s}, {27'd0, e_fl});
        chk("R11", "exc", {31'd0, g_exc}, {31'd0, e_fl != 0});
        chk("R11", "cause", {27'd0, g_cause}, {27'd0, model_cause});
        chk("R12", "sticky", {27'd0, g_stk}, {27'd0, model_stk});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] vals [12];
        vals[0]  = 32'h00000000; vals[1]  = 32'h80000000;
        vals[2]  = 32'h7F800000; vals[3]  = 32'hFF800000;
        vals[4]  = 32'h7FC00000; vals[5]  = 32'h7FA00000;
        vals[6]  = 32'h00000001; vals[7]  = 32'h80400000;
        vals[8]  = 32'h3F800000; vals[9]  = 32'hC0400000;
        vals[10] = 32'h7F000000; vals[11] = 32'h00800000;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "reset busy", {31'd0, busy_f}, 32'd0);
        chk("R12", "reset done", {31'd0, done_f}, 32'd0);
        chk("R12", "reset result", result_f, 32'd0);
        chk("R12", "reset cause", {27'd0, cause_f}, 32'd0);
        chk("R12", "reset flags", {22'd0, opfl_f, stk_f}, 32'd0);
        rst_n = 1'b1;

        // Priority sweep over all ordered pairs; trap_en alternates (R11)
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                run_op(vals[i], vals[j], ((i + j) % 3) == 0, 1'b0);
            end
        end

        // Directed rounding and range-limit cases (R1, R6, R7)
        run_op(32'h40400000, 32'h3F800000, 1'b0, 1'b0);
        run_op(32'h3F800001, 32'h3F800000, 1'b0, 1'b0);
        run_op(32'h3F7FFFFF, 32'h3F800000, 1'b0, 1'b0);
        run_op(32'h3F000000, 32'h7F7FFFFF, 1'b0, 1'b0);
        run_op(32'h3F800001, 32'h7F7FFFFF, 1'b0, 1'b0);
        run_op(32'h40000000, 32'h00800000, 1'b1, 1'b0);
        run_op(32'h3F7FFFFF, 32'h00800000, 1'b0, 1'b0);
        run_op(32'hC0E00000, 32'h41A80000, 1'b0, 1'b0);

        // R10: start pulse while busy is ignored
        run_op(32'h40A00000, 32'hC1200000, 1'b0, 1'b1);
        run_op(32'h00000000, 32'h3F800000, 1'b1, 1'b1);

        // Random normal operands across the exponent range (R1, R6, R7)
        for (int n = 0; n < 300; n++) begin
            logic [31:0] ra, rb;
            ra = {$urandom_range(1, 0) == 1, 8'(1 + $urandom_range(253, 0)), 23'($urandom)};
            rb = {$urandom_range(1, 0) == 1, 8'(1 + $urandom_range(253, 0)), 23'($urandom)};
            run_op(ra, rb, n[0], 1'b0);
        end

        summary();
    end
endmodule